// File: doc/BRIEF.md
# Bulk OUT Receive FIFO with Burst DMA Drain

This block is the receive side of a bulk OUT endpoint. Bytes from the serial engine are written into a 20-entry FIFO. That FIFO is smaller than the largest packet, which is 64 bytes, so a DMA engine has to empty it while the packet is still arriving. The block raises a DMA service request once 12 or more bytes are held. Each acknowledged request drains exactly 8 bytes, one per cycle.

A per-packet DMA byte budget of 56 bytes stops the DMA side short of a full packet. Whatever remains after the DMA side has finished is removed by the processor through a byte-wide read port, until the not-empty flag drops. The processor cannot see how many bytes the FIFO holds.

A packet-complete flag is set by the packet-end strobe and freezes reception. A sticky error flag collects three causes: line errors (CRC, bit stuffing), FIFO overrun and oversize packets. Software clears both flags with a single clear strobe, and that strobe also re-arms the endpoint for the next packet.

Top module: `usb_out_fifo`

## Requirements
- R1: The FIFO holds up to 20 bytes and returns them in arrival order. Exactly 20 bytes can be stored without raising the error flag.
- R2: A byte offered while the FIFO already holds 20 bytes is dropped and sets the error flag (overrun).
- R3: `dma_req` is high only when all four of these hold:
  - the FIFO holds 12 or more bytes;
  - no burst is running;
  - the error flag is clear;
  - the packet's DMA total plus 8 does not exceed 56.
  With a DMA agent that acknowledges every request, the DMA side ends a packet of length L ≥ 12 having taken 8·ceil((L−11)/8) bytes, capped at 56.
- R4: `dma_ack` sampled high while `dma_req` is high starts a burst. `dma_valid` is then high for exactly 8 consecutive cycles, beginning in the next cycle. `dma_data` carries the oldest byte in each of those cycles.
- R5: No more than 56 bytes of one packet leave through DMA. A 64-byte packet leaves 8 bytes in the FIFO, and a 60-byte packet leaves 4.
- R6: `cpu_data` always shows the oldest byte, and `rx_nempty` is high while any byte is held. `cpu_rd` removes one byte only when all three hold: a byte is held, the error flag is clear and no burst is running.
- R7: The error flag is set by an `rx_err` strobe, by an overrun or by an oversize byte, and it stays set until a clear. While it is set, `cpu_rd` has no effect and no DMA request is raised. A byte arriving with `rx_err` is still stored.
- R8: `rx_last` sets `pkt_done`. While `pkt_done` is set, incoming bytes are not stored and do not set the error flag.
- R9: A `pkt_clr` pulse clears `pkt_done`, the error flag, the packet byte count and the DMA total, and leaves the FIFO contents in place. The clear wins over any set event in the same cycle.
- R10: After reset the FIFO is empty, both flags are clear and no request is raised. Bytes are accepted immediately, without a clear.
- R11: The effective packet size limit is `cfg_maxp`, raised to 8 when set lower. Bytes of a packet beyond this limit are dropped and set the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_maxp | input | 7 | Configured maximum packet size in bytes |
| rx_valid | input | 1 | A received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Packet-end strobe |
| rx_err | input | 1 | Line error strobe (CRC or bit stuffing) |
| dma_req | output | 1 | DMA service request |
| dma_ack | input | 1 | DMA grants one 8-byte burst |
| dma_valid | output | 1 | A burst byte is on `dma_data` |
| dma_data | output | 8 | Burst byte |
| cpu_rd | input | 1 | Processor pops one byte |
| cpu_data | output | 8 | Oldest byte in the FIFO |
| rx_nempty | output | 1 | FIFO holds at least one byte |
| pkt_done | output | 1 | Packet-complete flag |
| rx_error | output | 1 | Sticky error flag |
| pkt_clr | input | 1 | Clears the flags and re-arms the endpoint |

## Verification
The bench sends packet lengths just below, at and above the 12-byte request threshold, and packets near and past the 56-byte budget. A design that compares against 8 instead of 12, or ignores the budget, would move the wrong number of bytes by DMA and leave the wrong remainder for the processor.

With DMA off, it fills the FIFO to exactly 20 bytes and then one byte further. An off-by-one capacity check would either flag a legal full FIFO or swallow the overrun.

It checks oversize packets with a size limit configured below 8, so a missing clamp shows up as a short packet. It also checks a line error in mid-packet, processor reads made while the error is set, bytes sent after packet end, and a clear issued in the same cycle as an error. In each case a wrong design would pop data it should keep, store bytes it should drop, or leave the error flag set.

// File: rtl/usbo_pkg.sv
package usbo_pkg;

    typedef logic [7:0] rx_byte_t;

    // packet-level status carried by the top module
    typedef struct packed {
        logic     done;
        logic     err;
        rx_byte_t len;
    } ep_state_t;

endpackage

// File: rtl/usbo_fifo_store.sv
module usbo_fifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 20,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [W-1:0]    push_data,
    input  logic            pop,
    output logic [W-1:0]    head,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);

    typedef struct packed {
        logic [PTRW-1:0] wr;
        logic [PTRW-1:0] rd;
        logic [LVLW-1:0] lvl;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTRW-1:0] wrap_inc(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = wrap_inc(s_q.wr);
        if (pop)  s_d.rd = wrap_inc(s_q.rd);
        case ({push, pop})
            2'b10:   s_d.lvl = s_q.lvl + 1'b1;
            2'b01:   s_d.lvl = s_q.lvl - 1'b1;
            default: s_d.lvl = s_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[s_q.wr] <= push_data;
    end

    assign head  = mem[s_q.rd];
    assign level = s_q.lvl;
    assign full  = (s_q.lvl == LVLW'(DEPTH));
    assign empty = (s_q.lvl == '0);

endmodule

// File: rtl/usbo_dma_burst.sv
module usbo_dma_burst #(
    parameter int LVLW  = 5,
    parameter int HWM   = 12,
    parameter int BURST = 8,
    parameter int LIMIT = 56,
    localparam int BW   = $clog2(BURST + 1),
    localparam int SW   = $clog2(LIMIT + BURST + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLW-1:0] level,
    input  logic            allow,
    input  logic            ack,
    input  logic            rearm,
    output logic            req,
    output logic            pop,
    output logic [SW-1:0]   sent
);

    typedef struct packed {
        logic [BW-1:0] beat;
        logic [SW-1:0] sent;
    } burst_t;

    burst_t b_d, b_q;
    logic   req_w;

    always_comb begin
        req_w = (b_q.beat == '0) && allow &&
                (level >= LVLW'(HWM)) &&
                ((b_q.sent + SW'(BURST)) <= SW'(LIMIT));
        b_d = b_q;
        if (b_q.beat != '0) b_d.beat = b_q.beat - 1'b1;
        if (req_w && ack) begin
            b_d.beat = BW'(BURST);
            b_d.sent = b_q.sent + SW'(BURST);
        end
        if (rearm) b_d.sent = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign req  = req_w;
    assign pop  = (b_q.beat != '0);
    assign sent = b_q.sent;

endmodule

// File: rtl/usb_out_fifo.sv
module usb_out_fifo
    import usbo_pkg::*;
#(
    parameter int DEPTH     = 20,
    parameter int HWM       = 12,
    parameter int BURST     = 8,
    parameter int DMA_LIMIT = 56,
    parameter int MAXP_MIN  = 8,
    localparam int LVLW     = $clog2(DEPTH + 1),
    localparam int DSW      = $clog2(DMA_LIMIT + BURST + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] cfg_maxp,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_last,
    input  logic       rx_err,
    output logic       dma_req,
    input  logic       dma_ack,
    output logic       dma_valid,
    output logic [7:0] dma_data,
    input  logic       cpu_rd,
    output logic [7:0] cpu_data,
    output logic       rx_nempty,
    output logic       pkt_done,
    output logic       rx_error,
    input  logic       pkt_clr
);

    ep_state_t       st_d, st_q;
    rx_byte_t        eff_max;
    rx_byte_t        head;
    logic [LVLW-1:0] fill_lvl;
    logic [DSW-1:0]  dma_sent;
    logic            full, empty;
    logic            byte_in, push, cpu_pop, dma_pop;

    always_comb begin
        eff_max = (cfg_maxp < 7'(MAXP_MIN)) ? rx_byte_t'(MAXP_MIN)
                                            : rx_byte_t'(cfg_maxp);
        byte_in = rx_valid && !st_q.done;
        push    = byte_in && !full && (st_q.len < eff_max);
        cpu_pop = cpu_rd && !st_q.err && !empty && !dma_pop;

        st_d = st_q;
        if (push) st_d.len = st_q.len + 1'b1;
        if (rx_err || (byte_in && !push)) st_d.err = 1'b1;
        if (rx_last) st_d.done = 1'b1;
        if (pkt_clr) begin
            st_d.done = 1'b0;
            st_d.err  = 1'b0;
            st_d.len  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    usbo_fifo_store #(
        .W     (8),
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_data),
        .pop       (cpu_pop | dma_pop),
        .head      (head),
        .level     (fill_lvl),
        .full      (full),
        .empty     (empty)
    );

    usbo_dma_burst #(
        .LVLW  (LVLW),
        .HWM   (HWM),
        .BURST (BURST),
        .LIMIT (DMA_LIMIT)
    ) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fill_lvl),
        .allow (!st_q.err),
        .ack   (dma_ack),
        .rearm (pkt_clr),
        .req   (dma_req),
        .pop   (dma_pop),
        .sent  (dma_sent)
    );

    assign dma_valid = dma_pop;
    assign dma_data  = head;
    assign cpu_data  = head;
    assign rx_nempty = !empty;
    assign pkt_done  = st_q.done;
    assign rx_error  = st_q.err;

endmodule

// File: rtl/usb_out_fifo_chk.sv
module usb_out_fifo_chk #(
    parameter int DEPTH = 20,
    parameter int HWM   = 12,
    parameter int BURST = 8,
    parameter int LIMIT = 56,
    parameter int LVLW  = 5,
    parameter int SW    = 7,
    localparam int BW   = $clog2(BURST + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [LVLW-1:0] level,
    input logic [SW-1:0]   sent,
    input logic            dma_req,
    input logic            dma_ack,
    input logic            dma_valid,
    input logic            rx_error,
    input logic            pkt_done,
    input logic            pkt_clr
);

    logic [BW:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (dma_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVLW'(DEPTH));

    // R3
    req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (level >= LVLW'(HWM)) && !rx_error && !dma_valid);

    // R4
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack |=> dma_valid);

    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_valid) |-> run_q == (BW+1)'(BURST));

    // R5
    dma_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sent <= SW'(LIMIT));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error && !pkt_clr |=> rx_error);

    // R7
    err_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error && !dma_valid |=> level >= $past(level));

    // R8
    done_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> level <= $past(level));

    // R9
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_clr |=> !pkt_done && !rx_error);

endmodule

bind usb_out_fifo usb_out_fifo_chk #(
    .DEPTH (DEPTH),
    .HWM   (HWM),
    .BURST (BURST),
    .LIMIT (DMA_LIMIT),
    .LVLW  (LVLW),
    .SW    (DSW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (fill_lvl),
    .sent      (dma_sent),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .dma_valid (dma_valid),
    .rx_error  (rx_error),
    .pkt_done  (pkt_done),
    .pkt_clr   (pkt_clr)
);

// File: tb/usb_out_fifo_tb.sv
`timescale 1ns/1ps
module usb_out_fifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_maxp = 7'd64;
    logic       rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       dma_req, dma_ack, dma_valid;
    logic [7:0] dma_data, cpu_data;
    logic       cpu_rd = 1'b0, pkt_clr = 1'b0;
    logic       rx_nempty, pkt_done, rx_error;

    always #2 clk = ~clk;

    usb_out_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_maxp(cfg_maxp),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_valid(dma_valid), .dma_data(dma_data),
        .cpu_rd(cpu_rd), .cpu_data(cpu_data), .rx_nempty(rx_nempty),
        .pkt_done(pkt_done), .rx_error(rx_error), .pkt_clr(pkt_clr)
    );

    typedef struct packed {
        logic [7:0] len;
        logic [6:0] maxp;
        logic       dma_en;
        logic [7:0] err_at;
        logic [7:0] exp_dma;
        logic [7:0] exp_left;
        logic       exp_err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd5,  7'd64, 1'b1, 8'd0, 8'd0,  8'd5,  1'b0},
        '{8'd11, 7'd64, 1'b1, 8'd0, 8'd0,  8'd11, 1'b0},
        '{8'd12, 7'd64, 1'b1, 8'd0, 8'd8,  8'd4,  1'b0},
        '{8'd20, 7'd64, 1'b1, 8'd0, 8'd16, 8'd4,  1'b0},
        '{8'd56, 7'd64, 1'b1, 8'd0, 8'd48, 8'd8,  1'b0},
        '{8'd60, 7'd64, 1'b1, 8'd0, 8'd56, 8'd4,  1'b0},
        '{8'd64, 7'd64, 1'b1, 8'd0, 8'd56, 8'd8,  1'b0},
        '{8'd20, 7'd64, 1'b0, 8'd0, 8'd0,  8'd20, 1'b0},
        '{8'd22, 7'd64, 1'b0, 8'd0, 8'd0,  8'd20, 1'b1},
        '{8'd10, 7'd3,  1'b0, 8'd0, 8'd0,  8'd8,  1'b1},
        '{8'd20, 7'd16, 1'b1, 8'd0, 8'd8,  8'd8,  1'b1},
        '{8'd6,  7'd64, 1'b1, 8'd3, 8'd0,  8'd6,  1'b1}
    };

    int         n_chk = 0, n_err = 0;
    int         dma_n = 0, left_n = 0;
    bit         dma_en = 1'b0, finished = 1'b0;
    logic [7:0] dma_buf [64];
    logic [7:0] cpu_buf [64];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int v, input int i);
        return 8'((v * 37 + i) & 255);
    endfunction

    // DMA agent: grants every request, collects burst bytes
    initial begin
        dma_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (dma_valid) begin
                if (dma_n < 64) dma_buf[dma_n] = dma_data;
                dma_n++;
            end
            dma_ack = dma_req && dma_en;
        end
    end

    task automatic clear_pkt();
        @(negedge clk); pkt_clr = 1'b1;
        @(negedge clk); pkt_clr = 1'b0;
    endtask

    task automatic send(input int v, input int len, input int err_at, input bit with_last);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(v, i);
            rx_last  = with_last && (i == len - 1);
            rx_err   = (i + 1 == err_at);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic drain();
        left_n = 0;
        @(negedge clk);
        while (rx_nempty && left_n < 64) begin
            cpu_buf[left_n] = cpu_data;
            left_n++;
            cpu_rd = 1'b1;
            @(negedge clk);
        end
        cpu_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        int         bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!pkt_done && !rx_error, "R10 flags after reset", {pkt_done, rx_error}, 0);
        chk(!rx_nempty && !dma_req && !dma_valid, "R10 empty/no request after reset",
            {rx_nempty, dma_req, dma_valid}, 0);
        // R10 accepts bytes before any clear
        send(99, 2, 0, 1'b0);
        chk(rx_nempty == 1'b1, "R10 byte accepted without clear", rx_nempty, 1);
        drain();
        chk(left_n == 2, "R10 bytes held after reset", left_n, 2);

        // table of packet scenarios
        for (int v = 0; v < NV; v++) begin
            cfg_maxp = VECS[v].maxp;
            dma_en   = VECS[v].dma_en;
            clear_pkt();
            dma_n = 0;
            send(v, int'(VECS[v].len), int'(VECS[v].err_at), 1'b1);
            repeat (24) @(negedge clk);
            chk(pkt_done == 1'b1, $sformatf("R8 done set vec%0d", v), pkt_done, 1);
            chk(rx_error == VECS[v].exp_err, $sformatf("R7 R2 R11 error flag vec%0d", v),
                rx_error, VECS[v].exp_err);
            chk(dma_n == int'(VECS[v].exp_dma), $sformatf("R3 R5 DMA bytes vec%0d", v),
                dma_n, VECS[v].exp_dma);
            if (rx_error) begin
                held = cpu_data;
                cpu_rd = 1'b1;
                @(negedge clk);
                cpu_rd = 1'b0;
                @(negedge clk);
                chk(cpu_data == held && rx_nempty, $sformatf("R7 read ignored vec%0d", v),
                    cpu_data, held);
                clear_pkt();
                chk(!rx_error && !pkt_done, $sformatf("R9 clear flags vec%0d", v),
                    {rx_error, pkt_done}, 0);
            end
            drain();
            chk(left_n == int'(VECS[v].exp_left), $sformatf("R6 R1 bytes left vec%0d", v),
                left_n, VECS[v].exp_left);
            bad = 0;
            for (int i = 0; i < int'(VECS[v].exp_dma) && i < dma_n; i++)
                if (dma_buf[i] != pat(v, i)) bad++;
            for (int i = 0; i < left_n; i++)
                if (cpu_buf[i] != pat(v, int'(VECS[v].exp_dma) + i)) bad++;
            chk(bad == 0, $sformatf("R4 R6 byte order vec%0d", v), bad, 0);
        end

        // R8 bytes after packet end are ignored and raise no error
        dma_en = 1'b0;
        cfg_maxp = 7'd64;
        clear_pkt();
        send(50, 3, 0, 1'b1);
        send(60, 2, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk(rx_error == 1'b0, "R8 no error for bytes after end", rx_error, 0);
        drain();
        chk(left_n == 3, "R8 bytes after end dropped", left_n, 3);

        // R9 clear wins over an error strobe in the same cycle
        clear_pkt();
        send(70, 1, 1, 1'b0);
        chk(rx_error == 1'b1, "R7 error strobe sets flag", rx_error, 1);
        @(negedge clk);
        pkt_clr = 1'b1; rx_err = 1'b1;
        @(negedge clk);
        pkt_clr = 1'b0; rx_err = 1'b0;
        chk(rx_error == 1'b0, "R9 clear beats same-cycle error", rx_error, 0);
        drain();
        chk(left_n == 1, "R9 clear keeps FIFO contents", left_n, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule